// File: doc/BRIEF.md
# Bridge-Sensor ADC Serial Reader

This block talks to a 24-bit bridge-sensor converter over two wires. It drives a serial clock line, which also serves as a power-down control, and it samples a data line that the converter uses both as a ready flag and as its serial output. When asked to read, the block waits for the converter to pull the data line low. It then clocks out the 24-bit two's-complement sample, most significant bit first. After the data it sends one, two or three further clock pulses, and their number tells the converter which input and gain to use for its next conversion.

The finished sample is sign-extended to the output width and presented for one cycle with a valid strobe. Each clock half-period, the sampling point inside the high phase, the power-down hold time and an optional wait limit are set as system-clock cycle counts, so a single instance can be fitted to any system clock. A separate request holds the clock line high long enough to power the converter down. The block then releases the line, which resets the converter, and sets its record of the converter's setting back to the default.

Top module: `bsadc_reader`

## Requirements
- R1: After reset, and whenever the block is idle, `adc_sck` is low. Reset clears `busy`, `data_valid`, `timeout_err` and `data` to zero and sets `cur_mode` to 2'b00.
- R2: A `start_read` while the synchronized `adc_dout` is high raises `busy` and keeps `adc_sck` low, with no pulses, until `adc_dout` goes low.
- R3: Once ready is seen, a read issues exactly 24 + N rising edges on `adc_sck`. N is 1 for selector 2'b00 (input A, gain 128), 2 for 2'b01 (input B, gain 32) and 3 for 2'b10 (input A, gain 64).
- R4: During a read, every high phase and every low phase between two pulses of `adc_sck` lasts exactly `HALF_CYC` system cycles. `adc_dout` is sampled `SAMPLE_DLY` cycles into each of the first 24 high phases.
- R5: `data` holds the 24 sampled bits, first bit as bit 23, sign-extended from bit 23 to `OUT_W` bits. `data` changes only in a cycle where `data_valid` is high.
- R6: `data_valid` is high for exactly one cycle per completed read, with `busy` high in that cycle. `busy` goes low in the following cycle.
- R7: `cur_mode` takes the selector of a read in the cycle in which that read's `data_valid` rises. Selector 2'b11 is handled as 2'b00 for both the pulse count and `cur_mode`, so `cur_mode` never reads 2'b11.
- R8: A `reset_req` accepted while idle holds `adc_sck` high for exactly `PD_HOLD_CYC` cycles and then drives it low, with `busy` high while the line is held. `cur_mode` returns to 2'b00 as the line drops. If `reset_req` and `start_read` arrive in the same idle cycle, the power-down sequence runs and no read starts.
- R9: If `adc_dout` stays high for `RDY_TIMEOUT` cycles of waiting (with `RDY_TIMEOUT` nonzero), `timeout_err` pulses for one cycle. In that same cycle `busy` is already low and no clock pulse has been sent.
- R10: While `busy` is high, `start_read` and `reset_req` have no effect. The current read completes with its own pulse count and high times, and no second read or power-down follows.
- R11: `mode` is captured only in the cycle `start_read` is accepted. Later changes on `mode` do not alter the trailing pulse count or `cur_mode` of that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_read | input | 1 | Request one conversion read (taken when idle) |
| mode | input | 2 | Input/gain selector applied to the converter's next conversion |
| reset_req | input | 1 | Request the power-down/reset sequence (taken when idle) |
| adc_dout | input | 1 | Converter data/ready line (high = not ready) |
| adc_sck | output | 1 | Converter serial clock / power-down line |
| busy | output | 1 | Block is waiting, reading or holding power-down |
| data_valid | output | 1 | One-cycle strobe marking a new result on `data` |
| data | output | OUT_W | Sign-extended conversion result |
| timeout_err | output | 1 | One-cycle strobe: ready never arrived within the limit |
| cur_mode | output | 2 | Selector the converter was last programmed with |

## Verification
The bench uses the extreme codes 0x7FFFFF, 0x800000 and 0xFFFFFF to catch a reversed bit order or a sign extension from the wrong bit. Any such fault shows up as a wrong `data` word. It sends every selector, including 2'b11, and counts the clock edges. A design that miscounts the trailing pulses, or that passes 2'b11 through unchanged, shows the wrong edge total or the wrong `cur_mode`. It changes `mode` during a read and issues `start_read` and `reset_req` while busy. A design that samples late or takes requests mid-read therefore sends the wrong pulse count, starts an unwanted second read, or stretches a high phase to the power-down length. It also tests the power-down hold length, the priority of power-down over a read requested in the same cycle, and the exact cycle of the wait timeout. An off-by-one counter fails at these points.

// File: rtl/bsadc_pkg.sv
package bsadc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_HIGH,
      ST_LOW,
      ST_DONE,
      ST_PDOWN
   } bsadc_state_e;

   // Selector codes: trailing pulse counts 1, 2, 3
   localparam logic [1:0] SEL_A128 = 2'b00;
   localparam logic [1:0] SEL_B32  = 2'b01;
   localparam logic [1:0] SEL_A64  = 2'b10;

   // Unused code folds onto the power-on default
   function automatic logic [1:0] sel_legal(input logic [1:0] s);
      return (s == 2'b11) ? SEL_A128 : s;
   endfunction

   function automatic logic [1:0] trail_pulses(input logic [1:0] s);
      logic [1:0] n;
      case (s)
         SEL_B32: n = 2'd2;
         SEL_A64: n = 2'd3;
         default: n = 2'd1;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/bsadc_sync.sv
module bsadc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/bsadc_shifter.sv
module bsadc_shifter #(
   parameter int DATA_BITS = 24,
   parameter int OUT_W     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_in,
   input  logic             load,
   output logic [OUT_W-1:0] word
);

   logic [DATA_BITS-1:0] sh;
   logic [OUT_W-1:0]     ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh <= '0;
      else if (shift_en) sh <= {sh[DATA_BITS-2:0], bit_in};
   end

   generate
      if (OUT_W == DATA_BITS) begin : g_exact
         assign ext = sh;
      end else begin : g_extend
         assign ext = {{(OUT_W-DATA_BITS){sh[DATA_BITS-1]}}, sh};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word <= '0;
      else if (load) word <= ext;
   end

endmodule

// File: rtl/bsadc_ready_wdog.sv
module bsadc_ready_wdog #(
   parameter int unsigned LIMIT = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic expired
);

   generate
      if (LIMIT == 0) begin : g_off
         logic unused_wdog;
         assign unused_wdog = ^{clk, rst_n, arm};
         assign expired     = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(LIMIT + 1);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (!arm) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end

         assign expired = arm && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/bsadc_reader.sv
module bsadc_reader
   import bsadc_pkg::*;
#(
   parameter int          DATA_BITS   = 24,
   parameter int          OUT_W       = 32,
   parameter int          HALF_CYC    = 100,
   parameter int          SAMPLE_DLY  = 50,
   parameter int          SYNC_STAGES = 2,
   parameter int          PD_HOLD_CYC = 7000,
   parameter int unsigned RDY_TIMEOUT = 25_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_read,
   input  logic [1:0]       mode,
   input  logic             reset_req,
   input  logic             adc_dout,
   output logic             adc_sck,
   output logic             busy,
   output logic             data_valid,
   output logic [OUT_W-1:0] data,
   output logic             timeout_err,
   output logic [1:0]       cur_mode
);

   localparam int TICK_TOP = (PD_HOLD_CYC > HALF_CYC) ? PD_HOLD_CYC : HALF_CYC;
   localparam int TICK_W   = $clog2(TICK_TOP + 1);
   localparam int IDX_W    = $clog2(DATA_BITS + 4);

   localparam logic [TICK_W-1:0] HALF_LAST = TICK_W'(HALF_CYC - 1);
   localparam logic [TICK_W-1:0] PD_LAST   = TICK_W'(PD_HOLD_CYC - 1);
   localparam logic [TICK_W-1:0] SMP_TICK  = TICK_W'(SAMPLE_DLY);
   localparam logic [IDX_W-1:0]  DBITS_I   = IDX_W'(DATA_BITS);
   localparam logic [IDX_W-1:0]  DLAST_I   = IDX_W'(DATA_BITS - 1);

   // Elaboration-time parameter checks
   generate
      if (DATA_BITS < 2) begin : g_bad_bits
         $error("bsadc_reader: DATA_BITS must be at least 2");
      end
      if (OUT_W < DATA_BITS) begin : g_bad_outw
         $error("bsadc_reader: OUT_W must not be below DATA_BITS");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("bsadc_reader: SYNC_STAGES must be at least 1");
      end
      if (SAMPLE_DLY < SYNC_STAGES || SAMPLE_DLY >= HALF_CYC) begin : g_bad_smp
         $error("bsadc_reader: SAMPLE_DLY must lie in [SYNC_STAGES, HALF_CYC-1]");
      end
      if (PD_HOLD_CYC <= HALF_CYC) begin : g_bad_pd
         $error("bsadc_reader: PD_HOLD_CYC must exceed HALF_CYC");
      end
   endgenerate

   bsadc_state_e      state, state_n;
   logic [TICK_W-1:0] tick, tick_n;
   logic [IDX_W-1:0]  idx, idx_n;
   logic [1:0]        sel_q, sel_n;
   logic [1:0]        mode_q, mode_n;
   logic              sck_q, tmo_q, tmo_n;
   logic              dout_s, tmo_hit, shift_en, load;
   logic [IDX_W-1:0]  total_last;

   bsadc_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (adc_dout),
      .q     (dout_s)
   );

   bsadc_ready_wdog #(
      .LIMIT (RDY_TIMEOUT)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (state == ST_WAIT),
      .expired (tmo_hit)
   );

   bsadc_shifter #(
      .DATA_BITS (DATA_BITS),
      .OUT_W     (OUT_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .bit_in   (dout_s),
      .load     (load),
      .word     (data)
   );

   // Index of the final pulse: data bits plus trailing selector pulses
   assign total_last = DLAST_I + {{(IDX_W-2){1'b0}}, trail_pulses(sel_q)};

   always_comb begin
      state_n  = state;
      tick_n   = tick + 1'b1;
      idx_n    = idx;
      sel_n    = sel_q;
      mode_n   = mode_q;
      tmo_n    = 1'b0;
      shift_en = 1'b0;
      load     = 1'b0;
      case (state)
         ST_IDLE: begin
            tick_n = '0;
            if (reset_req) begin
               state_n = ST_PDOWN;
            end else if (start_read) begin
               state_n = ST_WAIT;
               sel_n   = sel_legal(mode);
            end
         end
         ST_WAIT: begin
            tick_n = '0;
            if (!dout_s) begin
               state_n = ST_HIGH;
               idx_n   = '0;
            end else if (tmo_hit) begin
               state_n = ST_IDLE;
               tmo_n   = 1'b1;
            end
         end
         ST_HIGH: begin
            if (tick == SMP_TICK && idx < DBITS_I) shift_en = 1'b1;
            if (tick == HALF_LAST) begin
               state_n = ST_LOW;
               tick_n  = '0;
            end
         end
         ST_LOW: begin
            if (tick == HALF_LAST) begin
               tick_n = '0;
               if (idx == total_last) begin
                  state_n = ST_DONE;
                  load    = 1'b1;
                  mode_n  = sel_q;
               end else begin
                  state_n = ST_HIGH;
                  idx_n   = idx + 1'b1;
               end
            end
         end
         ST_DONE: begin
            state_n = ST_IDLE;
            tick_n  = '0;
         end
         ST_PDOWN: begin
            if (tick == PD_LAST) begin
               state_n = ST_IDLE;
               tick_n  = '0;
               mode_n  = SEL_A128;
            end
         end
         default: begin
            state_n = ST_IDLE;
            tick_n  = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         tick   <= '0;
         idx    <= '0;
         sel_q  <= SEL_A128;
         mode_q <= SEL_A128;
         sck_q  <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         state  <= state_n;
         tick   <= tick_n;
         idx    <= idx_n;
         sel_q  <= sel_n;
         mode_q <= mode_n;
         sck_q  <= (state_n == ST_HIGH) || (state_n == ST_PDOWN);
         tmo_q  <= tmo_n;
      end
   end

   assign adc_sck     = sck_q;
   assign busy        = (state != ST_IDLE);
   assign data_valid  = (state == ST_DONE);
   assign timeout_err = tmo_q;
   assign cur_mode    = mode_q;

endmodule

// File: rtl/bsadc_reader_chk.sv
module bsadc_reader_chk #(
   parameter int DATA_BITS   = 24,
   parameter int OUT_W       = 32,
   parameter int HALF_CYC    = 100,
   parameter int PD_HOLD_CYC = 7000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adc_sck,
   input logic             busy,
   input logic             data_valid,
   input logic [OUT_W-1:0] data,
   input logic             timeout_err,
   input logic [1:0]       cur_mode
);

   logic [31:0] hi_run;
   logic [7:0]  rise_cnt;
   logic        sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run   <= '0;
         rise_cnt <= '0;
         sck_d    <= 1'b0;
      end else begin
         sck_d <= adc_sck;
         if (!adc_sck)                    hi_run <= '0;
         else if (hi_run != 32'hFFFF_FFFF) hi_run <= hi_run + 1'b1;
         if (!busy)                       rise_cnt <= '0;
         else if (adc_sck && !sck_d)      rise_cnt <= rise_cnt + 1'b1;
      end
   end

   // R1
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !adc_sck);

   // R3
   pulse_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (rise_cnt >= 8'(DATA_BITS + 1) && rise_cnt <= 8'(DATA_BITS + 3)));

   // R4
   high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_sck) |-> (hi_run == 32'(HALF_CYC) || hi_run == 32'(PD_HOLD_CYC)));

   // R5
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data) |-> data_valid);

   // R6
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |=> !data_valid);

   // R6
   valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |=> !busy);

   // R7
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_mode != 2'b11);

   // R8
   mode_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_mode) |-> (data_valid || !busy));

   // R9
   timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> (!busy && !data_valid));

endmodule

bind bsadc_reader bsadc_reader_chk #(
   .DATA_BITS   (DATA_BITS),
   .OUT_W       (OUT_W),
   .HALF_CYC    (HALF_CYC),
   .PD_HOLD_CYC (PD_HOLD_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .adc_sck     (adc_sck),
   .busy        (busy),
   .data_valid  (data_valid),
   .data        (data),
   .timeout_err (timeout_err),
   .cur_mode    (cur_mode)
);

// File: tb/bsadc_reader_bench.sv
module bsadc_reader_bench;

   localparam int HALF = 4;
   localparam int SDLY = 2;
   localparam int SYNC = 2;
   localparam int PDH  = 40;
   localparam int TMO  = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_read = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        reset_req = 1'b0;
   logic        adc_dout;
   logic        adc_sck;
   logic        busy;
   logic        data_valid;
   logic [31:0] data;
   logic        timeout_err;
   logic [1:0]  cur_mode;

   always #5 clk = ~clk;

   bsadc_reader #(
      .DATA_BITS   (24),
      .OUT_W       (32),
      .HALF_CYC    (HALF),
      .SAMPLE_DLY  (SDLY),
      .SYNC_STAGES (SYNC),
      .PD_HOLD_CYC (PDH),
      .RDY_TIMEOUT (TMO)
   ) u_bsadc_reader (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_read  (start_read),
      .mode        (mode),
      .reset_req   (reset_req),
      .adc_dout    (adc_dout),
      .adc_sck     (adc_sck),
      .busy        (busy),
      .data_valid  (data_valid),
      .data        (data),
      .timeout_err (timeout_err),
      .cur_mode    (cur_mode)
   );

   // Converter model: low when ready, then one bit per rising edge, high after the data
   logic [23:0] adc_word = '0;
   logic        adc_rdy = 1'b0;
   int          adc_base = 0;
   int          rises_total = 0;
   int          rel;

   always @(posedge adc_sck) rises_total <= rises_total + 1;

   assign rel      = rises_total - adc_base;
   assign adc_dout = !adc_rdy ? 1'b1 :
                     (rel == 0) ? 1'b0 :
                     (rel <= 24) ? adc_word[24-rel] : 1'b1;

   typedef struct {
      logic [31:0] data;
      logic [1:0]  mode_after;
      int          pulses;
      int          base;
   } sb_item_t;

   sb_item_t sb_q[$];

   int  chk = 0, fail = 0;
   int  mon_chk = 0, mon_fail = 0;
   int  pd_cnt = 0;
   bit  pd_expect = 1'b0;
   bit  finished = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk++;
      if (!ok) begin
         fail++;
         $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on each result and measures clock phases
   sb_item_t it;
   int  hi_run = 0, lo_run = 0;
   bit  prev_sck = 1'b0, prev_valid = 1'b0, in_read_low = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (adc_sck) begin
            if (!prev_sck) begin
               if (in_read_low) begin
                  mon_chk++;
                  if (lo_run != HALF) begin
                     mon_fail++;
                     $display("FAIL R4 low phase act=%0d exp=%0d", lo_run, HALF);
                  end
               end
               hi_run = 1;
            end else hi_run++;
         end else begin
            if (prev_sck) begin
               mon_chk++;
               if (pd_expect) begin
                  pd_cnt++;
                  if (hi_run != PDH) begin
                     mon_fail++;
                     $display("FAIL R8 power-down hold act=%0d exp=%0d", hi_run, PDH);
                  end
               end else begin
                  if (hi_run != HALF) begin
                     mon_fail++;
                     $display("FAIL R4 high phase act=%0d exp=%0d", hi_run, HALF);
                  end
                  in_read_low = 1'b1;
               end
               lo_run = 1;
            end else lo_run++;
         end
         if (prev_valid) begin
            mon_chk++;
            if (data_valid || busy) begin
               mon_fail++;
               $display("FAIL R6 strobe/busy after result act=%0b%0b exp=00", data_valid, busy);
            end
         end
         if (data_valid) begin
            in_read_low = 1'b0;
            mon_chk++;
            if (sb_q.size() == 0) begin
               mon_fail++;
               $display("FAIL R10 unexpected result act=0x%08h exp=none", data);
            end else begin
               it = sb_q.pop_front();
               if (data !== it.data) begin
                  mon_fail++;
                  $display("FAIL R5 data act=0x%08h exp=0x%08h", data, it.data);
               end
               mon_chk++;
               if (cur_mode !== it.mode_after) begin
                  mon_fail++;
                  $display("FAIL R7 cur_mode act=%0d exp=%0d", cur_mode, it.mode_after);
               end
               mon_chk++;
               if (rises_total - it.base != it.pulses) begin
                  mon_fail++;
                  $display("FAIL R3 pulse count act=%0d exp=%0d", rises_total - it.base, it.pulses);
               end
               mon_chk++;
               if (!busy) begin
                  mon_fail++;
                  $display("FAIL R6 busy with strobe act=0 exp=1");
               end
            end
         end
         prev_sck   = adc_sck;
         prev_valid = data_valid;
      end
   end

   // Driver: pushes the expected result, then plays one read
   // poke: 0 none, 1 start_read mid-read, 2 reset_req mid-read, 3 change mode mid-read
   task automatic do_read(input logic [23:0] w, input logic [1:0] m, input int rdy_dly, input int poke);
      sb_item_t e;
      e.data       = {{8{w[23]}}, w};
      e.mode_after = (m == 2'b11) ? 2'b00 : m;
      e.pulses     = 24 + ((m == 2'b01) ? 2 : (m == 2'b10) ? 3 : 1);
      e.base       = rises_total;
      sb_q.push_back(e);
      adc_word = w;
      @(negedge clk);
      start_read = 1'b1;
      mode = m;
      @(negedge clk);
      start_read = 1'b0;
      if (poke == 3) mode = ~m;
      repeat (rdy_dly) @(negedge clk);
      // R2: waiting on a high data line, no pulses
      check(busy && !adc_sck && rises_total == e.base, "R2 wait without pulses",
            {30'd0, busy, adc_sck}, 32'h2);
      adc_base = rises_total;
      adc_rdy  = 1'b1;
      if (poke == 1 || poke == 2) begin
         repeat (20) @(negedge clk);
         if (poke == 1) begin start_read = 1'b1; mode = 2'b10; end
         else reset_req = 1'b1;
         @(negedge clk);
         start_read = 1'b0;
         reset_req  = 1'b0;
      end
      while (!data_valid) @(negedge clk);
      adc_rdy = 1'b0;
      repeat (12) @(negedge clk);
      // R10: no second read or power-down follows
      check(!busy && !adc_sck, "R10 idle after read", {30'd0, busy, adc_sck}, 32'h0);
      mode = 2'b00;
   endtask

   task automatic do_pdown(input bit with_start);
      int pd0, base;
      pd0  = pd_cnt;
      base = rises_total;
      pd_expect = 1'b1;
      @(negedge clk);
      reset_req = 1'b1;
      if (with_start) begin start_read = 1'b1; mode = 2'b01; end
      @(negedge clk);
      reset_req  = 1'b0;
      start_read = 1'b0;
      check(busy && adc_sck, "R8 line held high", {30'd0, busy, adc_sck}, 32'h3);
      while (busy) @(negedge clk);
      @(negedge clk);
      pd_expect = 1'b0;
      check(pd_cnt == pd0 + 1, "R8 hold completed", pd_cnt, pd0 + 1);
      check(cur_mode == 2'b00, "R8 mode back to default", {30'd0, cur_mode}, 32'h0);
      check(rises_total - base == 1, "R8 single rising edge", rises_total - base, 32'h1);
      mode = 2'b00;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!adc_sck && !busy && !data_valid && !timeout_err, "R1 outputs in reset",
            {28'd0, adc_sck, busy, data_valid, timeout_err}, 32'h0);
      check(data == 32'h0 && cur_mode == 2'b00, "R1 data and mode in reset", data, 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!adc_sck && !busy, "R1 idle after reset", {30'd0, adc_sck, busy}, 32'h0);

      do_read(24'h5A5A5A, 2'b00, 3, 0);   // R3 R5
      do_read(24'h7FFFFF, 2'b01, 5, 0);   // R3 R5 R7
      do_read(24'h800000, 2'b10, 4, 0);   // R3 R5 sign
      do_read(24'hFFFFFF, 2'b11, 3, 0);   // R7 illegal selector
      do_read(24'hA5C301, 2'b01, 40, 3);  // R11 mode change mid-read, R2 long wait
      check(cur_mode == 2'b01, "R11 mode kept from start", {30'd0, cur_mode}, 32'h1);

      do_pdown(1'b0);                     // R8 from idle
      do_read(24'h000000, 2'b10, 3, 0);
      do_pdown(1'b1);                     // R8 priority over start_read
      do_read(24'h123456, 2'b01, 3, 2);   // R10 reset_req ignored while busy
      check(cur_mode == 2'b01, "R10 mode after ignored power-down", {30'd0, cur_mode}, 32'h1);
      do_read(24'h00F00F, 2'b00, 3, 1);   // R10 start_read ignored while busy

      // R9: ready never arrives
      begin
         int n, base;
         base = rises_total;
         adc_rdy = 1'b0;
         @(negedge clk);
         start_read = 1'b1;
         @(negedge clk);
         start_read = 1'b0;
         n = 1;
         while (!timeout_err && n < 2 * TMO) begin
            @(negedge clk);
            n++;
         end
         check(n == TMO + 1, "R9 timeout cycle", n, TMO + 1);
         check(!busy && rises_total == base, "R9 idle without pulses", {31'd0, busy}, 32'h0);
         @(negedge clk);
         check(!timeout_err, "R9 single-cycle flag", {31'd0, timeout_err}, 32'h0);
      end

      repeat (10) @(negedge clk);
      check(sb_q.size() == 0, "R6 every expected result seen", sb_q.size(), 32'h0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", chk + mon_chk, fail + mon_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         $display("FAIL R6 run did not complete act=running exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", chk + mon_chk + 1, fail + mon_fail + 1);
         $finish;
      end
   end

endmodule